// File: doc/BRIEF.md
# Two-Wire Bus Master Transmitter with Coded Status Handshake

This block is a two-wire serial bus master that sends an address byte followed by any number of data bytes. Software drives it through three byte-wide registers: control, data and status. After each bus event the master halts, raises an interrupt flag and posts an 8-bit status code. It then holds the bus until software clears the flag. The control bits written in that same access choose the next step: send the byte in the data register, issue a repeated START, issue a STOP, or issue a STOP followed by a START.

The bus pins are open drain. The block outputs pull-down enables for SCL and SDA and reads back the wired bus levels. A bus monitor watches for START and STOP conditions from any master. A START request is held back while another master owns the bus. If the block sends a one but sees the line low, it has lost arbitration: it releases both lines and reports that.

Top module: `twi_master_tx`

## Requirements
- R1: After reset, status (address 2) reads 0xF8, control (address 0) reads 0x00, data (address 1) reads 0x00, the flag output is low and neither line is pulled low.
- R2: Clearing the flag with the start bit set produces status 0x08 when the bus was free and the block did not own it. It produces 0x10 when the block already owned the bus (repeated START).
- R3: The byte after a START is the address byte, sent MSB first; its LSB is the read/write bit, with write = 0. The acknowledge is sampled in the ninth clock (SDA low = ACK). Status is 0x18 on ACK and 0x20 on NACK.
- R4: A byte sent after the address is a data byte, sent MSB first. Status is 0x28 on ACK and 0x30 on NACK.
- R5: The flag (control bit 7, also on irq_o) is set at every status point. While it is set the block holds SCL low, and no transfer progresses until software writes control with bit 7 = 1 and enable (bit 0) = 1.
- R6: A data-register write while the flag is low is discarded and sets the write-collision bit (control bit 6). A data write while the flag is high stores the byte and clears that bit.
- R7: On a flag-clearing write, start (bit 1) alone issues START, stop (bit 2) alone issues STOP, both issue STOP then START, and neither sends the data register as the next byte.
- R8: After a STOP has been placed on the bus, the stop bit clears itself, status reads 0xF8, the flag stays low and both lines are released.
- R9: If the block releases SDA to send a one in an address or data bit and samples it low while SCL is high, it posts 0x38, sets the flag and releases both lines at once.
- R10: A requested START waits while the bus is busy. The bus becomes busy when a START is seen and free again when a STOP is seen; it is free after reset.
- R11: During a byte, SDA changes only while SCL is low. The only SDA edges with SCL high are START (falling) and STOP (rising).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt flag |
| scl_i | input | 1 | Wired SCL level |
| sda_i | input | 1 | Wired SDA level |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |

## Verification
A wrong sequencer state shows up at the next status point as a wrong status code or a flag that never rises, within one byte time of about 36 divider ticks. A wrong shift or bit count appears in the byte captured by the bench slave model. A stray SDA edge while SCL is high appears immediately as an extra START or STOP in the bench's bus-event count. A stuck busy tracker or a missed release after arbitration loss appears as a START that never arrives, or as a line still pulled low when the bench checks it.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam logic [7:0] ST_CODE_START = 8'h08;
  localparam logic [7:0] ST_CODE_RSTRT = 8'h10;
  localparam logic [7:0] ST_CODE_AACK  = 8'h18;
  localparam logic [7:0] ST_CODE_ANAK  = 8'h20;
  localparam logic [7:0] ST_CODE_DACK  = 8'h28;
  localparam logic [7:0] ST_CODE_DNAK  = 8'h30;
  localparam logic [7:0] ST_CODE_LOST  = 8'h38;
  localparam logic [7:0] ST_CODE_NONE  = 8'hF8;

  localparam int CB_EN   = 0;
  localparam int CB_STA  = 1;
  localparam int CB_STO  = 2;
  localparam int CB_WCOL = 6;
  localparam int CB_FLAG = 7;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_DATA = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  typedef enum logic [2:0] {
    XS_IDLE, XS_ARM, XS_START, XS_BYTE, XS_STOP, XS_HOLD
  } xfer_state_e;
endpackage

// File: rtl/twi_tick_gen.sv
module twi_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/twi_bus_monitor.sv
module twi_bus_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o
);
  logic scl_q, sda_q, start_det, stop_det;

  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_o <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_det)     busy_o <= 1'b1;
      else if (stop_det) busy_o <= 1'b0;
    end
  end

  assert_start_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> busy_o);
  assert_stop_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !busy_o);
endmodule

// File: rtl/twi_xfer_fsm.sv
module twi_xfer_fsm
  import twi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cmd_go_i,
  input  logic       cmd_sta_i,
  input  logic       cmd_sto_i,
  input  logic [7:0] tx_byte_i,
  input  logic       bus_busy_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       evt_o,
  output logic [7:0] evt_code_o,
  output logic       stop_done_o
);
  xfer_state_e state_q;
  logic [1:0]  ph_q;
  logic [3:0]  bit_q;
  logic [7:0]  sh_q;
  logic        own_q, addr_q, ack_q, pend_q, rep_q;
  logic        last_bit, lost;

  assign last_bit = (bit_q == 4'd8);
  // released SDA for a one, yet the line reads low with SCL high
  assign lost = (state_q == XS_BYTE) && tick_i && (ph_q == 2'd2)
              && !last_bit && !sda_oe_o && !sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      ph_q <= '0; bit_q <= '0; sh_q <= '0;
      own_q <= 1'b0; addr_q <= 1'b0; ack_q <= 1'b0;
      pend_q <= 1'b0; rep_q <= 1'b0;
      scl_oe_o <= 1'b0; sda_oe_o <= 1'b0;
      evt_o <= 1'b0; evt_code_o <= ST_CODE_NONE; stop_done_o <= 1'b0;
    end else begin
      evt_o       <= 1'b0;
      stop_done_o <= 1'b0;
      unique case (state_q)
        XS_IDLE: if (cmd_go_i && cmd_sta_i) state_q <= XS_ARM;
        XS_ARM: if (!bus_busy_i) begin
          state_q <= XS_START;
          ph_q    <= '0;
          rep_q   <= 1'b0;
        end
        XS_HOLD: if (cmd_go_i) begin
          ph_q <= '0;
          if (cmd_sto_i) begin
            state_q <= XS_STOP;
            pend_q  <= cmd_sta_i;
          end else if (cmd_sta_i) begin
            state_q <= XS_START;
            rep_q   <= 1'b1;
          end else begin
            state_q <= XS_BYTE;
            sh_q    <= tx_byte_i;
            bit_q   <= '0;
          end
        end
        XS_START: if (tick_i) begin
          ph_q <= ph_q + 1'b1;
          unique case (ph_q)
            2'd0: sda_oe_o <= 1'b0;
            2'd1: scl_oe_o <= 1'b0;
            2'd2: sda_oe_o <= 1'b1;
            default: begin
              scl_oe_o   <= 1'b1;
              evt_o      <= 1'b1;
              evt_code_o <= rep_q ? ST_CODE_RSTRT : ST_CODE_START;
              own_q      <= 1'b1;
              addr_q     <= 1'b1;
              state_q    <= XS_HOLD;
            end
          endcase
        end
        XS_BYTE: if (tick_i) begin
          ph_q <= ph_q + 1'b1;
          unique case (ph_q)
            2'd0: sda_oe_o <= !last_bit && !sh_q[7];
            2'd1: scl_oe_o <= 1'b0;
            2'd2: if (lost) begin
              scl_oe_o   <= 1'b0;
              sda_oe_o   <= 1'b0;
              evt_o      <= 1'b1;
              evt_code_o <= ST_CODE_LOST;
              own_q      <= 1'b0;
              addr_q     <= 1'b0;
              ph_q       <= '0;
              state_q    <= XS_IDLE;
            end else if (last_bit) begin
              ack_q <= !sda_i;
            end
            default: begin
              scl_oe_o <= 1'b1;
              if (last_bit) begin
                evt_o      <= 1'b1;
                evt_code_o <= addr_q ? (ack_q ? ST_CODE_AACK : ST_CODE_ANAK)
                                     : (ack_q ? ST_CODE_DACK : ST_CODE_DNAK);
                addr_q     <= 1'b0;
                state_q    <= XS_HOLD;
              end else begin
                sh_q  <= {sh_q[6:0], 1'b0};
                bit_q <= bit_q + 1'b1;
              end
            end
          endcase
        end
        XS_STOP: if (tick_i) begin
          ph_q <= ph_q + 1'b1;
          unique case (ph_q)
            2'd0: sda_oe_o <= 1'b1;
            2'd1: scl_oe_o <= 1'b0;
            2'd2: sda_oe_o <= 1'b0;
            default: begin
              own_q       <= 1'b0;
              stop_done_o <= 1'b1;
              state_q     <= pend_q ? XS_ARM : XS_IDLE;
            end
          endcase
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assert_hold_scl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XS_HOLD) |-> scl_oe_o);
  assert_sda_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XS_BYTE && !$stable(sda_oe_o)) |-> scl_oe_o);
  assert_lost_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && evt_code_o == ST_CODE_LOST) |-> (!scl_oe_o && !sda_oe_o && !own_q));
  assert_stop_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_done_o |-> (!scl_oe_o && !sda_oe_o));
endmodule

// File: rtl/twi_master_tx.sv
module twi_master_tx
  import twi_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic       flag_q, wcol_q, sta_q, sto_q, en_q;
  logic [7:0] data_q, status_q, evt_code;
  logic       tick, busy, evt, stop_done;
  logic       ctrl_wr, data_wr, cmd_go;

  assign ctrl_wr = reg_we_i && (reg_addr_i == RA_CTRL);
  assign data_wr = reg_we_i && (reg_addr_i == RA_DATA);
  assign cmd_go  = ctrl_wr && reg_wdata_i[CB_FLAG] && reg_wdata_i[CB_EN];
  assign irq_o   = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0; wcol_q <= 1'b0;
      sta_q  <= 1'b0; sto_q  <= 1'b0; en_q <= 1'b0;
      data_q <= '0;   status_q <= ST_CODE_NONE;
    end else begin
      if (ctrl_wr) begin
        en_q  <= reg_wdata_i[CB_EN];
        sta_q <= reg_wdata_i[CB_STA];
        sto_q <= reg_wdata_i[CB_STO];
        if (reg_wdata_i[CB_FLAG]) flag_q <= 1'b0;
      end
      if (data_wr) begin
        if (flag_q) begin
          data_q <= reg_wdata_i;
          wcol_q <= 1'b0;
        end else begin
          wcol_q <= 1'b1;
        end
      end
      if (evt) begin
        flag_q   <= 1'b1;
        status_q <= evt_code;
      end
      if (stop_done) begin
        sto_q    <= 1'b0;
        status_q <= ST_CODE_NONE;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RA_CTRL: reg_rdata_o = {flag_q, wcol_q, 3'b000, sto_q, sta_q, en_q};
      RA_DATA: reg_rdata_o = data_q;
      RA_STAT: reg_rdata_o = status_q;
      default: reg_rdata_o = 8'h00;
    endcase
  end

  twi_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  twi_bus_monitor u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i), .busy_o(busy)
  );

  twi_xfer_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .cmd_go_i(cmd_go), .cmd_sta_i(reg_wdata_i[CB_STA]), .cmd_sto_i(reg_wdata_i[CB_STO]),
    .tx_byte_i(data_q), .bus_busy_i(busy), .sda_i(sda_i),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .evt_o(evt), .evt_code_o(evt_code), .stop_done_o(stop_done)
  );

  assert_wcol_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !flag_q) |=> (wcol_q && $stable(data_q)));
  assert_sto_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_done && !ctrl_wr) |=> !sto_q);
  assert_flag_on_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> flag_q);
endmodule

// File: tb/twi_master_tx_tb.sv
module twi_master_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, scl_oe, sda_oe;
  logic       scl_w, sda_w;

  // bench-side bus agents
  logic tb_ack_low = 1'b0, tb_arb_low = 1'b0, tb_ext_low = 1'b0;
  logic ack_next = 1'b1, arb_en = 1'b0;
  int   arb_bit = 0;
  int   bitcnt = 0, starts = 0, stops = 0;
  logic [7:0] cap = 8'h00, last_byte = 8'h00;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  int n_chk = 0, n_fail = 0;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | tb_ack_low | tb_arb_low | tb_ext_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_master_tx #(.DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // slave / competitor model, sampled away from the active edge
  always @(negedge clk) begin
    if (prev_scl && scl_w && prev_sda && !sda_w) begin starts++; bitcnt = 0; end
    else if (prev_scl && scl_w && !prev_sda && sda_w) begin stops++; bitcnt = 0; end
    if (!prev_scl && scl_w) begin
      if (bitcnt < 8) cap = {cap[6:0], sda_w};
      bitcnt++;
      if (bitcnt == 8) last_byte = cap;
    end
    if (prev_scl && !scl_w) begin
      if (bitcnt == 8) tb_ack_low = ack_next;
      else if (bitcnt == 9) begin tb_ack_low = 1'b0; bitcnt = 0; end
      if (arb_en && bitcnt == arb_bit) tb_arb_low = 1'b1;
    end
    if (!arb_en) tb_arb_low = 1'b0;
    prev_scl = scl_w;
    prev_sda = sda_w;
  end

  function automatic logic [7:0] exp_code(input bit is_addr, input bit ack);
    if (is_addr) return ack ? 8'h18 : 8'h20;
    return ack ? 8'h28 : 8'h30;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_flag(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
    end
    check({req, " flag raised"}, int'(seen), 1);
  endtask

  task automatic wait_sto_clear(input string req);
    logic [7:0] c;
    bit done = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd0, c);
      if (!c[2]) begin done = 1'b1; break; end
    end
    check({req, " stop bit self-clear"}, int'(done), 1);
  endtask

  // send one byte through the handshake and check status and captured byte
  task automatic send(input logic [7:0] b, input bit is_addr, input bit ack, input string req);
    logic [7:0] s;
    ack_next = ack;
    wr(2'd1, b);
    wr(2'd0, 8'h81);
    wait_flag(req);
    rd(2'd2, s);
    check({req, " status"}, s, exp_code(is_addr, ack));
    check({req, " byte on bus MSB first"}, last_byte, b);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v, b;
    int s0, p0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(2'd2, v); check("R1 status", v, 8'hF8);
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 data", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 lines released", {scl_w, sda_w}, 2'b11);

    // R6 write collision while flag low
    wr(2'd1, 8'h5A);
    rd(2'd0, v); check("R6 wcol set", v[6], 1);
    rd(2'd1, v); check("R6 data discarded", v, 8'h00);

    s0 = starts; p0 = stops;
    // R2 start on free bus
    wr(2'd0, 8'h83);
    wait_flag("R2");
    rd(2'd2, v); check("R2 start status", v, 8'h08);
    // R5 bus suspended while flag set
    repeat (60) @(negedge clk);
    check("R5 flag held", irq, 1);
    check("R5 SCL held low", scl_w, 0);

    b = {7'($urandom()), 1'b0};
    ack_next = 1'b1;
    wr(2'd1, b);
    rd(2'd0, v); check("R6 wcol cleared by valid write", v[6], 0);
    wr(2'd0, 8'h81);
    wait_flag("R3");
    rd(2'd2, v); check("R3 address ACK status", v, 8'h18);
    check("R3 address byte", last_byte, b);

    // R4 random data bytes with random acknowledge
    for (int k = 0; k < 6; k++) begin
      send(8'($urandom()), 1'b0, 1'($urandom()), "R4");
    end
    send(8'hA5, 1'b0, 1'b0, "R4 NACK");

    // R2 repeated start, R3 address NACK
    wr(2'd0, 8'h83);
    wait_flag("R2 rep");
    rd(2'd2, v); check("R2 repeated start status", v, 8'h10);
    send({7'h2C, 1'b0}, 1'b1, 1'b0, "R3 NACK");

    // R7 stop followed by start
    wr(2'd0, 8'h87);
    wait_flag("R7");
    rd(2'd2, v); check("R7 stop+start gives fresh start", v, 8'h08);
    send({7'h11, 1'b0}, 1'b1, 1'b1, "R7 addr");

    // R8 stop only
    wr(2'd0, 8'h85);
    wait_sto_clear("R8");
    repeat (4) @(negedge clk);
    rd(2'd2, v); check("R8 status after stop", v, 8'hF8);
    check("R8 flag stays low", irq, 0);
    check("R8 lines released", {scl_w, sda_w}, 2'b11);

    // R11 only the intended starts and stops appeared
    check("R11 start count", starts - s0, 3);
    check("R11 stop count", stops - p0, 2);

    // R9 arbitration loss on data bit 3
    wr(2'd0, 8'h83);
    wait_flag("R9 start");
    send({7'h40, 1'b0}, 1'b1, 1'b1, "R9 addr");
    arb_bit = 3; arb_en = 1'b1;
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h81);
    wait_flag("R9");
    rd(2'd2, v); check("R9 lost status", v, 8'h38);
    check("R9 DUT releases both lines", {scl_oe, sda_oe}, 2'b00);
    @(negedge clk); arb_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 competitor STOP seen", sda_w, 1);

    // R10 START held back while another master owns the bus
    tb_ext_low = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h83);
    repeat (120) @(negedge clk);
    check("R10 no flag while busy", irq, 0);
    check("R10 no drive while busy", {scl_oe, sda_oe}, 2'b00);
    tb_ext_low = 1'b0;
    wait_flag("R10");
    rd(2'd2, v); check("R10 start after bus freed", v, 8'h08);
    wr(2'd0, 8'h85);
    wait_sto_clear("R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule